// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a synchronous host and an asynchronous dynamic RAM that has a 16-bit data bus and 10 multiplexed address lines. A host request carries a 20-bit word address, a write flag, one enable per byte lane, write data and a keep-open flag. The sequencer opens the row by lowering the row strobe with the upper address half on the bus. It then lowers the column strobes with the lower address half on the bus. When the access completes it pulses `h_done`. For a read, the data returned by the memory is on `h_rdata` in that same cycle.

Setting the keep-open flag leaves the row open after an access. A following request to the same row is then served by cycling only the column strobes. The open row is closed when a request arrives without the flag, when a request targets another row, when refresh is requested, or before the row strobe has been low for too long. Every analog limit is a nanosecond parameter. At elaboration each limit is rounded up to a whole number of periods of the clock given by `CLK_NS`. The only maximum limit, the row-strobe low time, is rounded down.

Host protocol: hold `h_req` and its fields stable until `h_done` is seen. In the cycle where `h_done` is high, either present the next request or drop `h_req`.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row address is `h_addr[19:10]`. It is on `dram_addr` when `dram_row_n` falls. The column address is `h_addr[9:0]`. It is on `dram_addr` when a column strobe falls, and it does not change while that strobe is low.
- R2: `h_be[0]` enables lane 0, meaning data bits 7:0 and strobe `dram_col_n[0]`. `h_be[1]` enables lane 1, meaning bits 15:8 and strobe `dram_col_n[1]`. Only the strobes of enabled lanes fall. A read returns zero in every disabled lane.
- R3: A write uses early timing. `dram_write_n` is low at least one cycle before a column strobe falls. `dram_dq_oe` is high, with the write data on `dram_dq_out`, while the strobe is low. `dram_out_en_n` stays high for the whole write.
- R4: During a read, `dram_out_en_n` is low, `dram_write_n` is high and `dram_dq_oe` is low. Read data is sampled only after all three access limits are met: row-to-data, column-address-to-data and column-strobe-to-data.
- R5: Once low, `dram_row_n` stays low for at least the minimum row pulse. Once high, it stays high for at least the row precharge time. Two falls of `dram_row_n` are at least one random cycle time apart.
- R6: A column strobe stays low for at least the minimum column pulse and high for at least the column precharge time. Two falls of the same strobe within an open row are at least one page cycle apart.
- R7: While each request has `h_cont` set and the next request targets the same row, the row strobe stays low and only the column strobes cycle.
- R8: The row is closed before the next access when the previous request had `h_cont` clear, or when the next request targets a different row. The pending request is then served after the precharge.
- R9: `dram_row_n` is never low for more than the row-low limit. An open row that is waiting for requests is closed before that limit is reached.
- R10: While `refresh_hold` is high, no row is opened. An open row is closed once its minimum row pulse has been met.
- R11: `h_done` is high for exactly one cycle per access. `h_rdata` is updated on reads only, in the same cycle as `h_done`.
- R12: After reset, all strobes and `dram_write_n`/`dram_out_en_n` are high, `dram_dq_oe` and `h_done` are low, and `h_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_req | input | 1 | Request present |
| h_addr | input | 20 | Word address, row in upper half |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_be | input | 2 | Byte lane enables |
| h_wdata | input | 16 | Write data |
| h_cont | input | 1 | Keep the row open after this access |
| refresh_hold | input | 1 | Close any open row and start no new one |
| h_rdata | output | 16 | Read data, valid with h_done |
| h_done | output | 1 | One-cycle completion pulse |
| dram_row_n | output | 1 | Row strobe, active low |
| dram_col_n | output | 2 | Column strobes per lane, active low |
| dram_write_n | output | 1 | Write enable, active low |
| dram_out_en_n | output | 1 | Memory output enable, active low |
| dram_addr | output | 10 | Multiplexed address |
| dram_dq_out | output | 16 | Data towards the memory |
| dram_dq_oe | output | 1 | Drive dram_dq_out onto the bus |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
A wrong wait count or saturating counter shows up first at the memory pins, as a strobe pulse one or more cycles too short. An early-sampling read makes the memory model return a poison pattern, which appears on `h_rdata` with the next `h_done`. A wrong row comparison or a stale keep-open flag changes the number of row-strobe falls in a burst. It also makes a read-back return data from the wrong row, and either effect is visible by the end of that burst. A lost guard or hold decision leaves the row strobe low. That is seen within the row-low limit, or within a few cycles of raising `refresh_hold`.

// File: rtl/fpm_pkg.sv
// Shared types and elaboration helpers for the page-mode DRAM sequencer.
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // row strobe high, waiting for a request
        ST_ROW,    // row strobe low, row address on the bus
        ST_ADDR,   // column address on the bus, column strobes high
        ST_COL,    // column strobes low
        ST_PAGE    // column strobes high, row still open
    } fpm_state_e;

    // Smallest whole number of clock periods covering a time in ns.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_sat_cnt.sv
// Saturating up-counter used as a timing stopwatch.
// Assumes: clr loads 1 so the cycle after clr reads 1; counting stops at MAXV.
module fpm_sat_cnt #(
    parameter int W    = 8,
    parameter int MAXV = 10,
    parameter int RSTV = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX_W = W'(MAXV);
    localparam logic [W-1:0] RST_W = W'(RSTV);

    // Count elapsed cycles, restart on clr, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= RST_W;
        else if (clr)              cnt <= W'(1);
        else if (en && cnt < MAX_W) cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/fpm_byte_lane.sv
// One byte lane: owns the column strobe of that lane and its read capture.
// Assumes: go_low and go_high are never raised together.
module fpm_byte_lane #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          go_low,
    input  logic          go_high,
    input  logic          capture,
    input  logic [BW-1:0] din,
    output logic          col_n,
    output logic [BW-1:0] rbyte
);
    // Lower the strobe only for an enabled lane; raise it when the column ends.
    always_ff @(posedge clk) begin
        if (!rst_n)               col_n <= 1'b1;
        else if (go_low && sel)   col_n <= 1'b0;
        else if (go_high)         col_n <= 1'b1;
    end

    // Take memory data for an enabled lane, zero for a disabled one.
    always_ff @(posedge clk) begin
        if (!rst_n)       rbyte <= '0;
        else if (capture) rbyte <= sel ? din : '0;
    end
endmodule

// File: rtl/fpm_dram_ctrl.sv
// Page-mode DRAM sequencer: turns host word requests into row/column strobe
// sequences, keeping a row open across same-row requests when asked.
// Assumes: host holds a request until h_done and replaces or drops it in the
// h_done cycle; every timing limit is converted to clock cycles here.
module fpm_dram_ctrl #(
    parameter int CLK_NS    = 10,
    parameter int AW        = 10,
    parameter int DW        = 16,
    parameter int T_RAS_NS  = 50,
    parameter int T_RC_NS   = 84,
    parameter int T_RP_NS   = 30,
    parameter int T_CAS_NS  = 8,
    parameter int T_CP_NS   = 9,
    parameter int T_PC_NS   = 20,
    parameter int T_RAC_NS  = 50,
    parameter int T_AA_NS   = 25,
    parameter int T_CAC_NS  = 13,
    parameter int T_RCD_NS  = 20,
    parameter int T_RASP_NS = 100000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_req,
    input  logic [2*AW-1:0]     h_addr,
    input  logic                h_wr,
    input  logic [DW/8-1:0]     h_be,
    input  logic [DW-1:0]       h_wdata,
    input  logic                h_cont,
    input  logic                refresh_hold,
    output logic [DW-1:0]       h_rdata,
    output logic                h_done,
    output logic                dram_row_n,
    output logic [DW/8-1:0]     dram_col_n,
    output logic                dram_write_n,
    output logic                dram_out_en_n,
    output logic [AW-1:0]       dram_addr,
    output logic [DW-1:0]       dram_dq_out,
    output logic                dram_dq_oe,
    input  logic [DW-1:0]       dram_dq_in
);
    import fpm_pkg::*;

    localparam int LANES    = DW / 8;
    localparam int RAS_CYC  = ns_to_cyc(T_RAS_NS, CLK_NS);
    localparam int RC_CYC   = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int RP_CYC   = ns_to_cyc(T_RP_NS, CLK_NS);
    localparam int CAS_CYC  = ns_to_cyc(T_CAS_NS, CLK_NS);
    localparam int CP_CYC   = ns_to_cyc(T_CP_NS, CLK_NS);
    localparam int PC_CYC   = ns_to_cyc(T_PC_NS, CLK_NS);
    localparam int RAC_CYC  = ns_to_cyc(T_RAC_NS, CLK_NS);
    localparam int AA_CYC   = ns_to_cyc(T_AA_NS, CLK_NS);
    localparam int CAC_CYC  = ns_to_cyc(T_CAC_NS, CLK_NS);
    localparam int RCD_CYC  = ns_to_cyc(T_RCD_NS, CLK_NS);
    localparam int LIM_CYC  = T_RASP_NS / CLK_NS;
    localparam int MARGIN   = 4 + PC_CYC + CP_CYC + max_of(max_of(AA_CYC, CAC_CYC), max_of(CAS_CYC, RAC_CYC));
    localparam int GUARD_AT = max_of(LIM_CYC - MARGIN, RAS_CYC);
    localparam int ST_MAX   = max_of(max_of(RCD_CYC, CAS_CYC), max_of(CAC_CYC, AA_CYC));
    localparam int CW       = $clog2(LIM_CYC + 2) + 2;

    localparam logic [CW-1:0] RAS_W   = CW'(RAS_CYC);
    localparam logic [CW-1:0] RC_W    = CW'(RC_CYC);
    localparam logic [CW-1:0] RP_W    = CW'(RP_CYC);
    localparam logic [CW-1:0] CAS_W   = CW'(CAS_CYC);
    localparam logic [CW-1:0] CP_W    = CW'(CP_CYC);
    localparam logic [CW-1:0] PC_W    = CW'(PC_CYC);
    localparam logic [CW-1:0] RAC_W   = CW'(RAC_CYC);
    localparam logic [CW-1:0] AA_W    = CW'(AA_CYC);
    localparam logic [CW-1:0] CAC_W   = CW'(CAC_CYC);
    localparam logic [CW-1:0] RCD_W   = CW'(RCD_CYC);
    localparam logic [CW-1:0] GUARD_W = CW'(GUARD_AT);

    fpm_state_e           state;
    logic [AW-1:0]        row_q, col_q;
    logic                 wr_q, cont_q;
    logic [LANES-1:0]     be_q;
    logic [DW-1:0]        wdata_q;

    logic [CW-1:0] ras_lo, ras_hi, rfall, cfall, chigh, stc;

    logic same_row, guard, end_burst, col_ok;
    logic start_row, row_done, enter_col, exit_col, close_row, next_col, state_chg;

    // Decide this cycle's state change from the stopwatches and the request.
    always_comb begin
        same_row  = (h_addr[2*AW-1:AW] == row_q);
        guard     = (ras_lo >= GUARD_W);
        end_burst = !cont_q || refresh_hold || guard || (h_req && !same_row);
        col_ok    = (stc >= CAS_W) &&
                    (wr_q || ((stc >= CAC_W) && ((stc + CW'(1)) >= AA_W) && (ras_lo >= RAC_W)));
        start_row = (state == ST_IDLE) && h_req && !refresh_hold &&
                    (ras_hi >= RP_W) && (rfall >= RC_W);
        row_done  = (state == ST_ROW) && (stc >= RCD_W);
        enter_col = (state == ST_ADDR) && (cfall >= PC_W) && (chigh >= CP_W);
        exit_col  = (state == ST_COL) && col_ok;
        close_row = (state == ST_PAGE) && end_burst && (ras_lo >= RAS_W);
        next_col  = (state == ST_PAGE) && !end_burst && h_req;
        state_chg = start_row | row_done | enter_col | exit_col | close_row | next_col;
    end

    // Stopwatches: row low time, row high time, row fall spacing,
    // column fall spacing, column high time, time in state.
    fpm_sat_cnt #(.W(CW), .MAXV(LIM_CYC), .RSTV(0)) u_ras_lo (
        .clk(clk), .rst_n(rst_n), .clr(start_row), .en(!dram_row_n), .cnt(ras_lo));
    fpm_sat_cnt #(.W(CW), .MAXV(RP_CYC), .RSTV(RP_CYC)) u_ras_hi (
        .clk(clk), .rst_n(rst_n), .clr(close_row), .en(dram_row_n), .cnt(ras_hi));
    fpm_sat_cnt #(.W(CW), .MAXV(RC_CYC), .RSTV(RC_CYC)) u_rfall (
        .clk(clk), .rst_n(rst_n), .clr(start_row), .en(1'b1), .cnt(rfall));
    fpm_sat_cnt #(.W(CW), .MAXV(PC_CYC), .RSTV(PC_CYC)) u_cfall (
        .clk(clk), .rst_n(rst_n), .clr(enter_col), .en(1'b1), .cnt(cfall));
    fpm_sat_cnt #(.W(CW), .MAXV(CP_CYC), .RSTV(CP_CYC)) u_chigh (
        .clk(clk), .rst_n(rst_n), .clr(exit_col), .en(1'b1), .cnt(chigh));
    fpm_sat_cnt #(.W(CW), .MAXV(ST_MAX), .RSTV(0)) u_stc (
        .clk(clk), .rst_n(rst_n), .clr(state_chg), .en(1'b1), .cnt(stc));

    // One lane block per byte: column strobe and read capture.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fpm_byte_lane #(.BW(8)) u_lane (
            .clk(clk), .rst_n(rst_n), .sel(be_q[i]),
            .go_low(enter_col), .go_high(exit_col), .capture(exit_col && !wr_q),
            .din(dram_dq_in[8*i +: 8]), .col_n(dram_col_n[i]), .rbyte(h_rdata[8*i +: 8]));
    end

    // Sequencer: state, row strobe, address mux, write/output controls, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            dram_row_n    <= 1'b1;
            dram_write_n  <= 1'b1;
            dram_out_en_n <= 1'b1;
            dram_dq_oe    <= 1'b0;
            dram_dq_out   <= '0;
            dram_addr     <= '0;
            h_done        <= 1'b0;
            row_q         <= '0;
            col_q         <= '0;
            wr_q          <= 1'b0;
            cont_q        <= 1'b0;
            be_q          <= '0;
            wdata_q       <= '0;
        end else begin
            h_done <= 1'b0;
            if (start_row) begin
                state         <= ST_ROW;
                row_q         <= h_addr[2*AW-1:AW];
                col_q         <= h_addr[AW-1:0];
                wr_q          <= h_wr;
                be_q          <= h_be;
                cont_q        <= h_cont;
                wdata_q       <= h_wdata;
                dram_row_n    <= 1'b0;
                dram_addr     <= h_addr[2*AW-1:AW];
                dram_write_n  <= !h_wr;
                dram_out_en_n <= h_wr;
            end else if (row_done) begin
                state       <= ST_ADDR;
                dram_addr   <= col_q;
                dram_dq_oe  <= wr_q;
                dram_dq_out <= wdata_q;
            end else if (enter_col) begin
                state <= ST_COL;
            end else if (exit_col) begin
                state         <= ST_PAGE;
                h_done        <= 1'b1;
                dram_write_n  <= 1'b1;
                dram_out_en_n <= 1'b1;
                dram_dq_oe    <= 1'b0;
            end else if (close_row) begin
                state      <= ST_IDLE;
                dram_row_n <= 1'b1;
            end else if (next_col) begin
                state         <= ST_ADDR;
                col_q         <= h_addr[AW-1:0];
                wr_q          <= h_wr;
                be_q          <= h_be;
                cont_q        <= h_cont;
                wdata_q       <= h_wdata;
                dram_addr     <= h_addr[AW-1:0];
                dram_write_n  <= !h_wr;
                dram_out_en_n <= h_wr;
                dram_dq_oe    <= h_wr;
                dram_dq_out   <= h_wdata;
            end
        end
    end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
// Protocol checker for fpm_dram_ctrl, bound onto every instance.
// Assumes: the same clock and reset as the checked block.
module fpm_dram_ctrl_chk #(
    parameter int CLK_NS    = 10,
    parameter int LANES     = 2,
    parameter int T_RAS_NS  = 50,
    parameter int T_RP_NS   = 30,
    parameter int T_RASP_NS = 100000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic [LANES-1:0] col_n,
    input logic             we_n,
    input logic             oe_n,
    input logic             dq_oe,
    input logic             done,
    input logic             refresh_hold
);
    localparam int RAS_CYC = (T_RAS_NS + CLK_NS - 1) / CLK_NS;
    localparam int RP_CYC  = (T_RP_NS + CLK_NS - 1) / CLK_NS;
    localparam int LIM_CYC = T_RASP_NS / CLK_NS;

    int lo_cnt;
    int hi_cnt;

    // Measure consecutive low and high cycles of the row strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= 0;
            hi_cnt <= RP_CYC;
        end else begin
            lo_cnt <= ras_n ? 0 : ((lo_cnt <= LIM_CYC) ? lo_cnt + 1 : lo_cnt);
            hi_cnt <= !ras_n ? 0 : ((hi_cnt < RP_CYC) ? hi_cnt + 1 : hi_cnt);
        end
    end

    a_r5_row_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> lo_cnt >= RAS_CYC);
    a_r5_row_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> hi_cnt >= RP_CYC);
    a_r9_row_low_max: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> lo_cnt < LIM_CYC);
    a_r3_bus_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && oe_n));
    a_r4_read_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !dq_oe));
    a_r6_col_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
        ras_n |-> (&col_n));
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_hold_no_open: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_hold && ras_n) |=> ras_n);

    for (genvar i = 0; i < LANES; i++) begin : g_we
        a_r3_we_leads_col: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(col_n[i]) && !we_n) |-> !$past(we_n));
    end
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
    .CLK_NS(CLK_NS), .LANES(DW/8), .T_RAS_NS(T_RAS_NS),
    .T_RP_NS(T_RP_NS), .T_RASP_NS(T_RASP_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_row_n), .col_n(dram_col_n),
    .we_n(dram_write_n), .oe_n(dram_out_en_n), .dq_oe(dram_dq_oe),
    .done(h_done), .refresh_hold(refresh_hold)
);

// File: tb/fpm_dram_ctrl_test.sv
// Directed bench with a cycle-level memory model that poisons early reads.
module fpm_dram_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0;
    logic [19:0] h_addr = '0;
    logic        h_wr = 1'b0;
    logic [1:0]  h_be = 2'b11;
    logic [15:0] h_wdata = '0;
    logic        h_cont = 1'b0;
    logic        refresh_hold = 1'b0;
    logic [15:0] h_rdata;
    logic        h_done;
    logic        dram_row_n;
    logic [1:0]  dram_col_n;
    logic        dram_write_n, dram_out_en_n, dram_dq_oe;
    logic [9:0]  dram_addr;
    logic [15:0] dram_dq_out, dram_dq_in;

    int n_chk = 0;
    int n_fail = 0;
    int row_falls = 0;

    fpm_dram_ctrl #(.T_RASP_NS(600)) uut (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_addr(h_addr), .h_wr(h_wr),
        .h_be(h_be), .h_wdata(h_wdata), .h_cont(h_cont), .refresh_hold(refresh_hold),
        .h_rdata(h_rdata), .h_done(h_done), .dram_row_n(dram_row_n),
        .dram_col_n(dram_col_n), .dram_write_n(dram_write_n),
        .dram_out_en_n(dram_out_en_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model, updated at falling edges (cycle counts include the current cycle).
    logic [15:0] mem [256];
    logic [9:0]  row_l = '0, col_l = '0, prev_addr = '0;
    logic        prev_row = 1'b1;
    logic [1:0]  prev_col = 2'b11;
    int ras_lo_c = 0, ras_hi_c = 100, since_fall = 100, addr_st = 0;
    int col_lo_c[2] = '{0, 0};
    int col_hi_c[2] = '{100, 100};
    int col_since[2] = '{100, 100};

    always @(negedge clk) begin
        if (rst_n) begin
            addr_st = (dram_addr == prev_addr) ? addr_st + 1 : 1;
            since_fall = since_fall + 1;
            if (prev_row && !dram_row_n) begin
                chk(ras_hi_c >= 3, "R5 row high min", ras_hi_c, 3);
                chk(since_fall - 1 >= 9, "R5 row cycle", since_fall - 1, 9);
                row_l = dram_addr; since_fall = 1; row_falls++;
            end
            if (!prev_row && dram_row_n) begin
                chk(ras_lo_c >= 5, "R5 row low min", ras_lo_c, 5);
                chk(ras_lo_c <= 60, "R9 row low max", ras_lo_c, 60);
            end
            ras_lo_c = dram_row_n ? 0 : ras_lo_c + 1;
            ras_hi_c = dram_row_n ? ras_hi_c + 1 : 0;
            for (int i = 0; i < 2; i++) begin
                col_since[i] = col_since[i] + 1;
                if (prev_col[i] && !dram_col_n[i]) begin
                    chk(col_hi_c[i] >= 1, "R6 column high min", col_hi_c[i], 1);
                    chk(col_since[i] - 1 >= 2, "R6 page cycle", col_since[i] - 1, 2);
                    col_since[i] = 1;
                    col_l = dram_addr;
                    if (!dram_write_n)
                        mem[{row_l[3:0], dram_addr[3:0]}][8*i +: 8] =
                            dram_dq_oe ? dram_dq_out[8*i +: 8] : 8'h99;
                end
                if (!prev_col[i] && dram_col_n[i])
                    chk(col_lo_c[i] >= 1, "R6 column low min", col_lo_c[i], 1);
                if (!dram_col_n[i])
                    chk(dram_addr == col_l, "R1 column address held", dram_addr, col_l);
                col_lo_c[i] = dram_col_n[i] ? 0 : col_lo_c[i] + 1;
                col_hi_c[i] = dram_col_n[i] ? col_hi_c[i] + 1 : 0;
            end
            prev_row = dram_row_n; prev_col = dram_col_n; prev_addr = dram_addr;
        end
    end

    // Data returned by the memory: poison until every access limit has passed.
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            if (dram_col_n[i])
                dram_dq_in[8*i +: 8] = 8'hEE;
            else if (!dram_out_en_n && col_lo_c[i] >= 2 && ras_lo_c >= 5 && addr_st >= 3)
                dram_dq_in[8*i +: 8] = mem[{row_l[3:0], col_l[3:0]}][8*i +: 8];
            else
                dram_dq_in[8*i +: 8] = 8'hAD;
        end
    end

    task automatic acc(input logic [19:0] a, input bit wr, input logic [1:0] be,
                       input logic [15:0] wd, input bit cont, output logic [15:0] rd);
        int n = 0;
        h_req = 1'b1; h_addr = a; h_wr = wr; h_be = be; h_wdata = wd; h_cont = cont;
        do begin @(negedge clk); n++; end while (!h_done && n < 300);
        chk(n < 300, "R11 access completes", n, 0);
        rd = h_rdata;
    endtask

    task automatic idle();
        h_req = 1'b0; h_cont = 1'b0;
    endtask

    function automatic logic [19:0] ad(input int r, input int c);
        return {10'(r), 10'(c)};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(dram_row_n && (&dram_col_n) && dram_write_n && dram_out_en_n,
            "R12 strobes idle", {dram_row_n, dram_col_n, dram_write_n, dram_out_en_n}, 5'h1f);
        chk(!dram_dq_oe && !h_done && h_rdata == 0, "R12 outputs clear",
            {dram_dq_oe, h_done, h_rdata}, 0);
    endtask

    task automatic t_word();
        logic [15:0] rd;
        acc(ad(1, 2), 1, 2'b11, 16'h1234, 0, rd);
        acc(ad(2, 2), 1, 2'b11, 16'hABCD, 0, rd);
        acc(ad(1, 2), 0, 2'b11, 16'h0, 0, rd);
        chk(rd == 16'h1234, "R1 R4 word read row 1", rd, 16'h1234);
        acc(ad(2, 2), 0, 2'b11, 16'h0, 0, rd);
        chk(rd == 16'hABCD, "R1 R3 word read row 2", rd, 16'hABCD);
        idle();
        @(negedge clk);
        chk(!h_done, "R11 done single cycle", h_done, 0);
    endtask

    task automatic t_bytes();
        logic [15:0] rd;
        acc(ad(1, 2), 1, 2'b01, 16'hFF55, 0, rd);
        acc(ad(1, 2), 0, 2'b11, 16'h0, 0, rd);
        chk(rd == 16'h1255, "R2 lower lane write", rd, 16'h1255);
        acc(ad(1, 2), 1, 2'b10, 16'h66FF, 0, rd);
        acc(ad(1, 2), 0, 2'b11, 16'h0, 0, rd);
        chk(rd == 16'h6655, "R2 upper lane write", rd, 16'h6655);
        acc(ad(1, 2), 0, 2'b01, 16'h0, 0, rd);
        chk(rd == 16'h0055, "R2 disabled lane reads zero", rd, 16'h0055);
        idle();
    endtask

    task automatic t_burst();
        logic [15:0] rd;
        int f0;
        repeat (4) @(negedge clk);
        f0 = row_falls;
        for (int c = 3; c < 7; c++) acc(ad(3, c), 1, 2'b11, 16'(16'h3000 + c), c != 6, rd);
        idle();
        repeat (10) @(negedge clk);
        chk(row_falls - f0 == 1, "R7 write burst one row open", row_falls - f0, 1);
        f0 = row_falls;
        for (int c = 3; c < 7; c++) begin
            acc(ad(3, c), 0, 2'b11, 16'h0, c != 6, rd);
            chk(rd == 16'(16'h3000 + c), "R7 burst read data", rd, 16'h3000 + c);
        end
        idle();
        repeat (10) @(negedge clk);
        chk(row_falls - f0 == 1, "R7 read burst one row open", row_falls - f0, 1);
    endtask

    task automatic t_close();
        logic [15:0] rd;
        int f0 = row_falls;
        acc(ad(3, 4), 0, 2'b11, 16'h0, 1, rd);
        acc(ad(2, 2), 0, 2'b11, 16'h0, 1, rd);
        chk(rd == 16'hABCD, "R8 new row after row change", rd, 16'hABCD);
        acc(ad(2, 2), 0, 2'b11, 16'h0, 0, rd);
        acc(ad(2, 2), 0, 2'b11, 16'h0, 0, rd);
        idle();
        repeat (10) @(negedge clk);
        chk(row_falls - f0 == 3, "R8 row closes on change and on clear flag", row_falls - f0, 3);
    endtask

    task automatic t_guard();
        logic [15:0] rd;
        int n = 0;
        acc(ad(5, 1), 0, 2'b11, 16'h0, 1, rd);
        idle();
        while (!dram_row_n && n < 100) begin @(negedge clk); n++; end
        chk(dram_row_n && n < 60, "R9 idle open row closed before limit", n, 60);
    endtask

    task automatic t_hold();
        logic [15:0] rd;
        int f0, n = 0;
        bit seen = 0;
        repeat (5) @(negedge clk);
        refresh_hold = 1'b1;
        f0 = row_falls;
        h_req = 1'b1; h_addr = ad(3, 5); h_wr = 0; h_be = 2'b11; h_cont = 0;
        repeat (20) begin @(negedge clk); seen |= h_done; end
        chk(row_falls == f0 && dram_row_n && !seen, "R10 no row opened under hold",
            row_falls - f0, 0);
        refresh_hold = 1'b0;
        acc(ad(3, 5), 0, 2'b11, 16'h0, 1, rd);
        chk(rd == 16'h3005, "R10 held request served after release", rd, 16'h3005);
        idle();
        refresh_hold = 1'b1;
        while (!dram_row_n && n < 20) begin @(negedge clk); n++; end
        chk(dram_row_n && n < 8, "R10 open row closed under hold", n, 8);
        refresh_hold = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word();
        t_bytes();
        t_burst();
        t_close();
        t_guard();
        t_hold();
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule